// File: doc/BRIEF.md
# Interrupt Pending Arbiter with Timer

This block holds the pending and enable bits of a hart's interrupt sources and a timer compare value. A free-running real-time count is compared against the compare value every cycle. When the count reaches the compare value, the block latches a machine-timer pending bit. That bit stays set until software writes the compare register again.

Every cycle, the block also decides whether an interrupt should be taken and which cause it carries. It uses four inputs for this: the current privilege level, the global interrupt enable, the pending and enable bits, and a flag that says a host message is waiting. The processor around it does the vectoring and the privilege stack updates.

Software reaches the registers through one write-data bus and six select lines. Four selects write the machine-wide and supervisor-restricted views of the pending and enable registers. One select is a software-interrupt poke, and one writes the compare register. Each view has its own read-data output.

Top module: `intr_pend_arb`

## Requirements
- R1: After reset, the pending and enable registers read 0, the compare register reads all-ones and no interrupt is taken.
- R2: A machine pending write updates only bits 1 (supervisor software), 3 (machine software) and 5 (supervisor timer). Bit 7 (machine timer) keeps its value. The machine pending view reads back all four bits.
- R3: A machine enable write updates bits 1, 3, 5 and 7, and leaves every other bit at 0.
- R4: A supervisor pending write updates only bit 1. The supervisor pending view reads the pending register masked to bits 1 and 5.
- R5: A supervisor enable write updates only bits 1 and 5. The supervisor enable view reads the enable register masked to bits 1 and 5.
- R6: A poke write of any data value sets pending bit 3 at the next clock edge. The poke view always reads 0.
- R7: Pending bit 7 is set at the first clock edge where the real-time count is greater than or equal to the compare value. It stays set until a compare write, and a compare write clears it at that edge. The compare view reads the last value written.
- R8: Machine-level causes are eligible when the privilege is below machine (U=0, S=1), or when it is machine (3) and the global enable is 1.
- R9: Among machine-level causes, the order is software (pending and enable bit 3, cause 0), then timer (bit 7, cause 1), then host message (cause 2). The host cause needs no enable bit.
- R10: Supervisor-level causes are eligible when the privilege is user, or when it is supervisor and the global enable is 1. They are considered only when no machine cause is taken. Software (bit 1, cause 0) goes before timer (bit 5, cause 1).
- R11: The take flag and the cause follow the current register state and the current inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privLvl | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| globalIe | input | 1 | Global interrupt enable at the current privilege |
| rtcCount | input | CNT_W | Free-running real-time count |
| hostMsgPending | input | 1 | Host mailbox is nonzero |
| selMPend | input | 1 | Write strobe, machine pending view |
| selMEn | input | 1 | Write strobe, machine enable view |
| selSPend | input | 1 | Write strobe, supervisor pending view |
| selSEn | input | 1 | Write strobe, supervisor enable view |
| selPoke | input | 1 | Write strobe, software-interrupt poke |
| selCmp | input | 1 | Write strobe, timer compare |
| wrData | input | DATA_W | Write data |
| mPendRd | output | DATA_W | Machine pending view |
| mEnRd | output | DATA_W | Machine enable view |
| sPendRd | output | DATA_W | Supervisor pending view |
| sEnRd | output | DATA_W | Supervisor enable view |
| pokeRd | output | DATA_W | Poke view, constant 0 |
| cmpRd | output | CNT_W | Timer compare view |
| takeIrq | output | 1 | An interrupt should be taken |
| irqCause | output | 2 | Cause code of the selected interrupt |

## Verification
A register write lands at the clock edge that samples its select, and the read views show it right after that edge. The bench therefore drives a write for one cycle and reads back at the following falling edge.

The timer pending bit needs one edge after the count reaches the compare value, so the bench holds the count across exactly one edge before it checks. The take flag and the cause are combinational. The bench changes privilege, enable or host inputs at a falling edge and samples them a short delay later, in the same cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int IRQ_W     = 8;
  localparam int SSIP_BIT  = 1;
  localparam int MSIP_BIT  = 3;
  localparam int STIP_BIT  = 5;
  localparam int MTIP_BIT  = 7;

  localparam logic [IRQ_W-1:0] SSIP_MASK = IRQ_W'(1) << SSIP_BIT;
  localparam logic [IRQ_W-1:0] MSIP_MASK = IRQ_W'(1) << MSIP_BIT;
  localparam logic [IRQ_W-1:0] STIP_MASK = IRQ_W'(1) << STIP_BIT;
  localparam logic [IRQ_W-1:0] MTIP_MASK = IRQ_W'(1) << MTIP_BIT;

  localparam logic [IRQ_W-1:0] M_PEND_WMASK = SSIP_MASK | MSIP_MASK | STIP_MASK;
  localparam logic [IRQ_W-1:0] M_EN_WMASK   = M_PEND_WMASK | MTIP_MASK;
  localparam logic [IRQ_W-1:0] S_PEND_WMASK = SSIP_MASK;
  localparam logic [IRQ_W-1:0] S_VIEW_MASK  = SSIP_MASK | STIP_MASK;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    CAUSE_SW   = 2'd0,
    CAUSE_TMR  = 2'd1,
    CAUSE_HOST = 2'd2
  } cause_e;

  typedef struct packed {
    logic wrMPend;
    logic wrMEn;
    logic wrSPend;
    logic wrSEn;
    logic poke;
    logic wrCmp;
  } strobe_t;
endpackage

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selMPend,
  input  logic             selMEn,
  input  logic             selSPend,
  input  logic             selSEn,
  input  logic             selPoke,
  input  logic             selCmp,
  input  logic [1:0]       privLvl,
  input  logic             globalIe,
  input  logic             hostMsgPending,
  input  logic [IRQ_W-1:0] pendQ,
  input  logic [IRQ_W-1:0] enQ,
  output strobe_t          strb,
  output logic             takeIrq,
  output logic [1:0]       irqCause
);
  logic [IRQ_W-1:0] active;
  logic mElig, sElig;
  cause_e cause;

  always_comb begin
    strb.wrMPend = selMPend;
    strb.wrMEn   = selMEn;
    strb.wrSPend = selSPend;
    strb.wrSEn   = selSEn;
    strb.poke    = selPoke;
    strb.wrCmp   = selCmp;
  end

  assign active = pendQ & enQ;
  assign mElig  = (privLvl != PRIV_M) || globalIe;
  assign sElig  = (privLvl == PRIV_U) || ((privLvl == PRIV_S) && globalIe);

  always_comb begin
    takeIrq = 1'b0;
    cause   = CAUSE_SW;
    if (mElig && |(active & MSIP_MASK)) begin
      takeIrq = 1'b1; cause = CAUSE_SW;
    end else if (mElig && |(active & MTIP_MASK)) begin
      takeIrq = 1'b1; cause = CAUSE_TMR;
    end else if (mElig && hostMsgPending) begin
      takeIrq = 1'b1; cause = CAUSE_HOST;
    end else if (sElig && |(active & SSIP_MASK)) begin
      takeIrq = 1'b1; cause = CAUSE_SW;
    end else if (sElig && |(active & STIP_MASK)) begin
      takeIrq = 1'b1; cause = CAUSE_TMR;
    end
  end
  assign irqCause = cause;

  // R8: machine with enable clear blocks every cause
  p_blocked_in_m_r8: assert property (@(posedge clk) disable iff (!rstN)
    (privLvl == PRIV_M && !globalIe) |-> !takeIrq);
  // R9: a waiting host message below or at an open machine level is taken
  p_host_taken_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostMsgPending && (privLvl != PRIV_M || globalIe)) |-> takeIrq);
  // R10: no take at all without a pending-enabled pair or a host message
  p_take_has_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> ((|active) || hostMsgPending));
  // R11: cause stays in the defined code set
  p_cause_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (irqCause != 2'd3));
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  rtcCount,
  output logic [IRQ_W-1:0]  pendQ,
  output logic [IRQ_W-1:0]  enQ,
  output logic [CNT_W-1:0]  cmpQ
);
  logic [IRQ_W-1:0] pendD, enD, wrLow;
  logic [CNT_W-1:0] cmpD;

  assign wrLow = wrData[IRQ_W-1:0];

  always_comb begin
    pendD = pendQ;
    if (strb.wrMPend) pendD = (pendD & ~M_PEND_WMASK) | (wrLow & M_PEND_WMASK);
    if (strb.wrSPend) pendD = (pendD & ~S_PEND_WMASK) | (wrLow & S_PEND_WMASK);
    if (strb.poke)    pendD = pendD | MSIP_MASK;
    if (strb.wrCmp)   pendD = pendD & ~MTIP_MASK;
    else if (rtcCount >= cmpQ) pendD = pendD | MTIP_MASK;
  end

  always_comb begin
    enD = enQ;
    if (strb.wrMEn) enD = (enD & ~M_EN_WMASK) | (wrLow & M_EN_WMASK);
    if (strb.wrSEn) enD = (enD & ~S_VIEW_MASK) | (wrLow & S_VIEW_MASK);
  end

  assign cmpD = strb.wrCmp ? CNT_W'(wrData) : cmpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      enQ   <= '0;
      cmpQ  <= '1;
    end else begin
      pendQ <= pendD;
      enQ   <= enD;
      cmpQ  <= cmpD;
    end
  end

  // R7: compare write leaves the timer bit clear
  p_cmp_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmp |=> !pendQ[MTIP_BIT]);
  // R7: timer bit is sticky without a compare write
  p_mtip_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ[MTIP_BIT] && !strb.wrCmp) |=> pendQ[MTIP_BIT]);
  // R6: poke always raises machine software pending
  p_poke_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.poke |=> pendQ[MSIP_BIT]);
  // R3: unimplemented enable bits never become set
  p_en_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enQ & ~M_EN_WMASK) == '0);
endmodule

// File: rtl/intr_pend_arb.sv
module intr_pend_arb
  import intr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        privLvl,
  input  logic              globalIe,
  input  logic [CNT_W-1:0]  rtcCount,
  input  logic              hostMsgPending,
  input  logic              selMPend,
  input  logic              selMEn,
  input  logic              selSPend,
  input  logic              selSEn,
  input  logic              selPoke,
  input  logic              selCmp,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] mPendRd,
  output logic [DATA_W-1:0] mEnRd,
  output logic [DATA_W-1:0] sPendRd,
  output logic [DATA_W-1:0] sEnRd,
  output logic [DATA_W-1:0] pokeRd,
  output logic [CNT_W-1:0]  cmpRd,
  output logic              takeIrq,
  output logic [1:0]        irqCause
);
  strobe_t          strb;
  logic [IRQ_W-1:0] pendQ, enQ;

  intr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .selMPend(selMPend), .selMEn(selMEn), .selSPend(selSPend),
    .selSEn(selSEn), .selPoke(selPoke), .selCmp(selCmp),
    .privLvl(privLvl), .globalIe(globalIe), .hostMsgPending(hostMsgPending),
    .pendQ(pendQ), .enQ(enQ), .strb(strb),
    .takeIrq(takeIrq), .irqCause(irqCause)
  );

  intr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rtcCount(rtcCount), .pendQ(pendQ), .enQ(enQ), .cmpQ(cmpRd)
  );

  assign mPendRd = DATA_W'(pendQ);
  assign mEnRd   = DATA_W'(enQ);
  assign sPendRd = DATA_W'(pendQ & S_VIEW_MASK);
  assign sEnRd   = DATA_W'(enQ & S_VIEW_MASK);
  assign pokeRd  = '0;
endmodule

// File: tb/intr_pend_arb_tb.sv
module intr_pend_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {priv[22:21], ie[20], host[19], pend[18:11], en[10:3], take[2], cause[1:0]}
  localparam logic [22:0] VECS [0:NVEC-1] = '{
    {2'd3, 1'b1, 1'b0, 8'h08, 8'h08, 1'b1, 2'd0},  // R8 R9 M open, msw
    {2'd3, 1'b0, 1'b0, 8'h08, 8'h08, 1'b0, 2'd0},  // R8 M closed
    {2'd1, 1'b0, 1'b0, 8'h08, 8'h08, 1'b1, 2'd0},  // R8 below M
    {2'd3, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 2'd2},  // R9 host no enable
    {2'd3, 1'b1, 1'b0, 8'h2A, 8'h00, 1'b0, 2'd0},  // R11 pending not enabled
    {2'd1, 1'b1, 1'b0, 8'h22, 8'h22, 1'b1, 2'd0},  // R10 ssw before stimer
    {2'd1, 1'b0, 1'b0, 8'h20, 8'h20, 1'b0, 2'd0},  // R10 S closed
    {2'd0, 1'b0, 1'b0, 8'h20, 8'h20, 1'b1, 2'd1},  // R10 user, stimer
    {2'd0, 1'b0, 1'b1, 8'h22, 8'h22, 1'b1, 2'd2},  // R10 machine host first
    {2'd3, 1'b1, 1'b0, 8'h02, 8'h02, 1'b0, 2'd0},  // R10 S cause in M
    {2'd0, 1'b0, 1'b0, 8'h28, 8'h20, 1'b1, 2'd1}   // R11 msw not enabled
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] privLvl = 2'd3;
  logic globalIe = 1'b0, hostMsgPending = 1'b0;
  logic [31:0] rtcCount = '0;
  logic selMPend = 0, selMEn = 0, selSPend = 0, selSEn = 0, selPoke = 0, selCmp = 0;
  logic [31:0] wrData = '0;
  logic [31:0] mPendRd, mEnRd, sPendRd, sEnRd, pokeRd, cmpRd;
  logic takeIrq;
  logic [1:0] irqCause;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_pend_arb u_dut (
    .clk(clk), .rstN(rstN), .privLvl(privLvl), .globalIe(globalIe),
    .rtcCount(rtcCount), .hostMsgPending(hostMsgPending),
    .selMPend(selMPend), .selMEn(selMEn), .selSPend(selSPend),
    .selSEn(selSEn), .selPoke(selPoke), .selCmp(selCmp), .wrData(wrData),
    .mPendRd(mPendRd), .mEnRd(mEnRd), .sPendRd(sPendRd), .sEnRd(sEnRd),
    .pokeRd(pokeRd), .cmpRd(cmpRd), .takeIrq(takeIrq), .irqCause(irqCause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWr(input int which, input logic [31:0] d);
    @(negedge clk);
    wrData = d;
    case (which)
      0: selMPend = 1'b1;
      1: selMEn   = 1'b1;
      2: selSPend = 1'b1;
      3: selSEn   = 1'b1;
      4: selPoke  = 1'b1;
      default: selCmp = 1'b1;
    endcase
    @(negedge clk);
    {selMPend, selMEn, selSPend, selSEn, selPoke, selCmp} = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pend", mPendRd, 32'h0);
    check("R1 en", mEnRd, 32'h0);
    check("R1 cmp", cmpRd, 32'hFFFF_FFFF);
    check("R1 take", {31'b0, takeIrq}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      doWr(1, {24'b0, VECS[i][10:3]});
      doWr(0, {24'b0, VECS[i][18:11]});
      privLvl = VECS[i][22:21];
      globalIe = VECS[i][20];
      hostMsgPending = VECS[i][19];
      #1;
      check($sformatf("R11 vec%0d take", i), {31'b0, takeIrq}, {31'b0, VECS[i][2]});
      if (VECS[i][2])
        check($sformatf("R9 R10 vec%0d cause", i), {30'b0, irqCause}, {30'b0, VECS[i][1:0]});
    end
    hostMsgPending = 1'b0;

    doWr(0, 32'hFFFF_FFFF);
    check("R2 mpend mask", mPendRd, 32'h2A);
    check("R4 spend view", sPendRd, 32'h22);
    doWr(1, 32'hFFFF_FFFF);
    check("R3 men mask", mEnRd, 32'hAA);
    check("R5 sen view", sEnRd, 32'h22);
    doWr(0, 32'h0);
    doWr(2, 32'hFFFF_FFFF);
    check("R4 spend write", mPendRd, 32'h02);
    doWr(1, 32'h0);
    doWr(3, 32'hFFFF_FFFF);
    check("R5 sen write", mEnRd, 32'h22);
    doWr(0, 32'h0);
    doWr(1, 32'h0);

    doWr(5, 32'd100);
    rtcCount = 32'd50;
    @(negedge clk);
    check("R7 below cmp", mPendRd, 32'h0);
    check("R7 cmp read", cmpRd, 32'd100);
    rtcCount = 32'd100;
    @(negedge clk);
    check("R7 reach cmp", mPendRd, 32'h80);
    rtcCount = 32'd0;
    @(negedge clk);
    check("R7 sticky", mPendRd, 32'h80);
    doWr(1, 32'h80);
    privLvl = 2'd3; globalIe = 1'b1; hostMsgPending = 1'b1;
    #1;
    check("R9 timer over host take", {31'b0, takeIrq}, 32'h1);
    check("R9 timer over host", {30'b0, irqCause}, 32'd1);
    hostMsgPending = 1'b0;
    doWr(4, 32'h0);
    check("R6 poke sets", mPendRd, 32'h88);
    check("R6 poke reads 0", pokeRd, 32'h0);
    doWr(1, 32'h88);
    #1;
    check("R9 sw over timer", {30'b0, irqCause}, 32'd0);
    doWr(0, 32'h0);
    check("R2 mtip not writable", mPendRd, 32'h80);
    doWr(5, 32'd200);
    check("R7 cmp write clears", mPendRd, 32'h0);
    check("R7 cmp new", cmpRd, 32'd200);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule